// File: doc/BRIEF.md
# Search Key Mask Selection Unit

This block sits at the front of a ternary search slice. It keeps two banks of key-width registers. The first bank holds captured search keys, called comparands. The second bank holds global masks. Within each bank the registers are grouped as even/odd pairs, and a small index on each command picks one pair.

A search presents its key over one cycle (narrow mode) or two cycles (wide mode). The first cycle is stored in the even register of the chosen comparand pair, and the second cycle in the odd register. Each key half is compared against a small ternary table of stored words under the matching half of the selected global mask pair. The block returns a per-entry match vector, a hit flag and the lowest matching entry.

The same mask pair gates bit writes into the table. A learn command copies a stored comparand pair into a table entry. Both register banks and the table can be read back through combinational ports.

Top module: `skm_unit`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) clears every comparand register, every mask register, every table data and care bit, the pending wide-search state, res_valid, match_vec, hit and hit_idx to zero.
- R2: A configuration write (cfg_we=1) stores cfg_data, in one cycle, into the register numbered cfg_addr (5 bits). cfg_bank=0 selects the comparand bank and cfg_bank=1 selects the mask bank. rd_data combinationally shows the register named by rd_bank/rd_addr, using the same bank encoding.
- R3: Commands are encoded in cmd_op as 0 = search first cycle (A), 1 = search second cycle (B), 2 = masked write, 3 = learn. An accepted A cycle stores cmd_data into comparand register 2*cmd_cidx. An accepted B cycle stores it into register 2*cmd_cidx+1.
- R4: Mask index n (cmd_midx) selects mask registers 2n (even) and 2n+1 (odd). The A cycle and table half 0 (bits 71:0) use the even register. The B cycle and table half 1 (bits 143:72) use the odd register.
- R5: A key bit compares as a match when its global mask bit is 0, or when the entry's care bit (mask table, 1 = compare) is 0, or when the key bit equals the stored data bit.
- R6: An A cycle with cmd_wide=0 produces res_valid=1 one cycle later. match_vec then has bit e set when entry e's low half matches the key.
- R7: An A cycle with cmd_wide=1 produces no result by itself. A B cycle in the very next cycle produces res_valid=1 one cycle after the B cycle. The match vector is then the AND of the low-half and high-half matches. A B cycle that does not directly follow a wide A cycle is ignored: it stores nothing and produces no result.
- R8: hit is 1 when any match_vec bit is set, and hit_idx is then the lowest set bit position. With no bit set, hit and hit_idx are 0.
- R9: A masked write (cmd_op=2) updates the selected half (cmd_half) of entry cmd_entry in the data table (cmd_tsel=0) or the care table (cmd_tsel=1). Only bits whose mask bit is 1 in register 2*cmd_midx+cmd_half take the new value; all other bits keep their stored value.
- R10: A learn (cmd_op=3) writes {comparand 2c+1, comparand 2c} (c = cmd_cidx, even register in bits 71:0) into the data table of entry cmd_entry and leaves its care bits unchanged.
- R11: res_valid is high only in the cycle after a completing search. match_vec holds its value in every cycle where res_valid is 0.
- R12: tbl_rd_data and tbl_rd_mask combinationally show the data and care words of entry tbl_rd_entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Register programming strobe |
| cfg_bank | input | 1 | 0 comparand bank, 1 mask bank |
| cfg_addr | input | 5 | Register number within bank |
| cfg_data | input | 72 | Register write value |
| rd_bank | input | 1 | Readback bank select |
| rd_addr | input | 5 | Readback register number |
| rd_data | output | 72 | Readback value |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 0 search A, 1 search B, 2 write, 3 learn |
| cmd_wide | input | 1 | Search A is the first of two cycles |
| cmd_cidx | input | 4 | Comparand pair index |
| cmd_midx | input | 4 | Global mask pair index |
| cmd_entry | input | 4 | Table entry for write and learn |
| cmd_tsel | input | 1 | Write target: 0 data, 1 care |
| cmd_half | input | 1 | Write half: 0 low, 1 high |
| cmd_data | input | 72 | Key half or write data |
| tbl_rd_entry | input | 4 | Table readback entry |
| tbl_rd_data | output | 144 | Data word of that entry |
| tbl_rd_mask | output | 144 | Care word of that entry |
| res_valid | output | 1 | Search result strobe |
| match_vec | output | 16 | Per-entry match flags |
| hit | output | 1 | Any entry matched |
| hit_idx | output | 4 | Lowest matching entry |

## Verification
The bench builds the block with its default parameters: 72-bit halves, 16 register pairs per bank and 16 table entries. With these values the top entry, 15, is reachable, so the lowest-index encoder is tested at both ends of the vector. Learned keys and mask pairs at both even and odd positions are also reachable. A behavioural model tracks every register and table word. It is compared with the outputs each cycle, through directed cases and a long random phase that mixes orphan second cycles, interrupted wide searches and partial-mask writes.

// File: rtl/skm_pkg.sv
package skm_pkg;
   typedef enum logic [1:0] {
      OP_SRCH_A = 2'd0,
      OP_SRCH_B = 2'd1,
      OP_WRITE  = 2'd2,
      OP_LEARN  = 2'd3
   } skm_op_e;
endpackage

// File: rtl/skm_regbank.sv
module skm_regbank #(
   parameter int DW   = 72,
   parameter int NREG = 32,
   localparam int AW  = $clog2(NREG),
   localparam int PW  = AW - 1
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          w0_en,
   input  logic [AW-1:0] w0_addr,
   input  logic [DW-1:0] w0_data,
   input  logic          w1_en,
   input  logic [AW-1:0] w1_addr,
   input  logic [DW-1:0] w1_data,
   input  logic [AW-1:0] rd_addr,
   output logic [DW-1:0] rd_data,
   input  logic [PW-1:0] pair_idx,
   output logic [DW-1:0] pair_even,
   output logic [DW-1:0] pair_odd
);
   logic [DW-1:0] regs [NREG];

   generate
      for (genvar r = 0; r < NREG; r++) begin : g_reg
         always_ff @(posedge clk) begin
            if (rst)
               regs[r] <= '0;
            else if (w1_en && w1_addr == AW'(r))
               regs[r] <= w1_data;
            else if (w0_en && w0_addr == AW'(r))
               regs[r] <= w0_data;
         end
      end
   endgenerate

   assign rd_data   = regs[rd_addr];
   assign pair_even = regs[{pair_idx, 1'b0}];
   assign pair_odd  = regs[{pair_idx, 1'b1}];
endmodule

// File: rtl/skm_table.sv
module skm_table #(
   parameter int DW   = 72,
   parameter int NENT = 16,
   localparam int EW  = $clog2(NENT),
   localparam int WW  = 2 * DW
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            wr_en,
   input  logic [EW-1:0]   wr_entry,
   input  logic            wr_tsel,
   input  logic            wr_half,
   input  logic [DW-1:0]   wr_data,
   input  logic [DW-1:0]   wr_gmask,
   input  logic            lrn_en,
   input  logic [EW-1:0]   lrn_entry,
   input  logic [WW-1:0]   lrn_data,
   input  logic            cmp_half,
   input  logic [DW-1:0]   cmp_key,
   input  logic [DW-1:0]   cmp_gmask,
   output logic [NENT-1:0] cmp_vec,
   input  logic [EW-1:0]   rd_entry,
   output logic [WW-1:0]   rd_data,
   output logic [WW-1:0]   rd_mask
);
   logic [WW-1:0] dat [NENT];
   logic [WW-1:0] car [NENT];
   logic [WW-1:0] wen;
   logic [WW-1:0] wval;

   assign wen  = wr_half ? {wr_gmask, {DW{1'b0}}} : {{DW{1'b0}}, wr_gmask};
   assign wval = {wr_data, wr_data};

   generate
      for (genvar e = 0; e < NENT; e++) begin : g_ent
         logic sel_w;
         logic [DW-1:0] dh;
         logic [DW-1:0] ch;
         assign sel_w = wr_en && wr_entry == EW'(e);

         always_ff @(posedge clk) begin
            if (rst) begin
               dat[e] <= '0;
               car[e] <= '0;
            end else if (lrn_en && lrn_entry == EW'(e)) begin
               dat[e] <= lrn_data;
            end else if (sel_w && !wr_tsel) begin
               dat[e] <= (dat[e] & ~wen) | (wval & wen);
            end else if (sel_w && wr_tsel) begin
               car[e] <= (car[e] & ~wen) | (wval & wen);
            end
         end

         assign dh = cmp_half ? dat[e][WW-1:DW] : dat[e][DW-1:0];
         assign ch = cmp_half ? car[e][WW-1:DW] : car[e][DW-1:0];
         assign cmp_vec[e] = &(~cmp_gmask | ~ch | ~(dh ^ cmp_key));
      end
   endgenerate

   assign rd_data = dat[rd_entry];
   assign rd_mask = car[rd_entry];
endmodule

// File: rtl/skm_prio.sv
module skm_prio #(
   parameter int N  = 16,
   localparam int IW = $clog2(N)
) (
   input  logic [N-1:0]  vec,
   output logic          any,
   output logic [IW-1:0] idx
);
   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (vec[i]) idx = IW'(i);
      end
   end
   assign any = |vec;
endmodule

// File: rtl/skm_unit.sv
module skm_unit #(
   parameter int DW     = 72,
   parameter int NPAIRS = 16,
   parameter int NENT   = 16,
   localparam int NREG  = 2 * NPAIRS,
   localparam int RAW   = $clog2(NREG),
   localparam int PIW   = $clog2(NPAIRS),
   localparam int EIW   = $clog2(NENT)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             cfg_we,
   input  logic             cfg_bank,
   input  logic [RAW-1:0]   cfg_addr,
   input  logic [DW-1:0]    cfg_data,
   input  logic             rd_bank,
   input  logic [RAW-1:0]   rd_addr,
   output logic [DW-1:0]    rd_data,
   input  logic             cmd_valid,
   input  logic [1:0]       cmd_op,
   input  logic             cmd_wide,
   input  logic [PIW-1:0]   cmd_cidx,
   input  logic [PIW-1:0]   cmd_midx,
   input  logic [EIW-1:0]   cmd_entry,
   input  logic             cmd_tsel,
   input  logic             cmd_half,
   input  logic [DW-1:0]    cmd_data,
   input  logic [EIW-1:0]   tbl_rd_entry,
   output logic [2*DW-1:0]  tbl_rd_data,
   output logic [2*DW-1:0]  tbl_rd_mask,
   output logic             res_valid,
   output logic [NENT-1:0]  match_vec,
   output logic             hit,
   output logic [EIW-1:0]   hit_idx
);
   import skm_pkg::*;

   generate
      if (DW < 1) begin : g_bad_dw
         $error("skm_unit: DW must be positive");
      end
      if (NPAIRS < 2 || (NPAIRS & (NPAIRS - 1)) != 0) begin : g_bad_pairs
         $error("skm_unit: NPAIRS must be a power of two, at least 2");
      end
      if (NENT < 2 || (NENT & (NENT - 1)) != 0) begin : g_bad_ent
         $error("skm_unit: NENT must be a power of two, at least 2");
      end
   endgenerate

   skm_op_e op;
   logic is_a, is_b_ok, do_wr, do_lrn, sel_half;
   logic pend_q;
   logic [NENT-1:0] pvec_q;
   logic [NENT-1:0] cmp_vec;
   logic [DW-1:0] c_rd, c_even, c_odd, m_rd, m_even, m_odd, gmask;

   assign op       = skm_op_e'(cmd_op);
   assign is_a     = cmd_valid && op == OP_SRCH_A;
   assign is_b_ok  = cmd_valid && op == OP_SRCH_B && pend_q;
   assign do_wr    = cmd_valid && op == OP_WRITE;
   assign do_lrn   = cmd_valid && op == OP_LEARN;
   assign sel_half = (op == OP_SRCH_B) || (op == OP_WRITE && cmd_half);
   assign gmask    = sel_half ? m_odd : m_even;

   skm_regbank #(.DW(DW), .NREG(NREG)) u_cmp_bank (
      .clk(clk), .rst(rst),
      .w0_en(cfg_we && !cfg_bank), .w0_addr(cfg_addr), .w0_data(cfg_data),
      .w1_en(is_a || is_b_ok), .w1_addr({cmd_cidx, is_b_ok}), .w1_data(cmd_data),
      .rd_addr(rd_addr), .rd_data(c_rd),
      .pair_idx(cmd_cidx), .pair_even(c_even), .pair_odd(c_odd)
   );

   skm_regbank #(.DW(DW), .NREG(NREG)) u_msk_bank (
      .clk(clk), .rst(rst),
      .w0_en(cfg_we && cfg_bank), .w0_addr(cfg_addr), .w0_data(cfg_data),
      .w1_en(1'b0), .w1_addr('0), .w1_data('0),
      .rd_addr(rd_addr), .rd_data(m_rd),
      .pair_idx(cmd_midx), .pair_even(m_even), .pair_odd(m_odd)
   );

   assign rd_data = rd_bank ? m_rd : c_rd;

   skm_table #(.DW(DW), .NENT(NENT)) u_table (
      .clk(clk), .rst(rst),
      .wr_en(do_wr), .wr_entry(cmd_entry), .wr_tsel(cmd_tsel), .wr_half(cmd_half),
      .wr_data(cmd_data), .wr_gmask(gmask),
      .lrn_en(do_lrn), .lrn_entry(cmd_entry), .lrn_data({c_odd, c_even}),
      .cmp_half(op == OP_SRCH_B), .cmp_key(cmd_data), .cmp_gmask(gmask),
      .cmp_vec(cmp_vec),
      .rd_entry(tbl_rd_entry), .rd_data(tbl_rd_data), .rd_mask(tbl_rd_mask)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         pend_q    <= 1'b0;
         pvec_q    <= '0;
         res_valid <= 1'b0;
         match_vec <= '0;
      end else begin
         pend_q    <= is_a && cmd_wide;
         res_valid <= (is_a && !cmd_wide) || is_b_ok;
         if (is_a) pvec_q <= cmp_vec;
         if (is_a && !cmd_wide)
            match_vec <= cmp_vec;
         else if (is_b_ok)
            match_vec <= pvec_q & cmp_vec;
      end
   end

   skm_prio #(.N(NENT)) u_prio (
      .vec(match_vec), .any(hit), .idx(hit_idx)
   );
endmodule

// File: rtl/skm_unit_chk.sv
module skm_unit_chk #(
   parameter int NENT = 16,
   localparam int EIW = $clog2(NENT)
) (
   input logic            clk,
   input logic            rst,
   input logic            cmd_valid,
   input logic [1:0]      cmd_op,
   input logic            cmd_wide,
   input logic            res_valid,
   input logic [NENT-1:0] match_vec,
   input logic            hit,
   input logic [EIW-1:0]  hit_idx
);
   import skm_pkg::*;

   logic [NENT-1:0] below;
   assign below = (NENT'(1) << hit_idx) - NENT'(1);

   a_r6_narrow_next: assert property (@(posedge clk) disable iff (rst)
      (cmd_valid && cmd_op == OP_SRCH_A && !cmd_wide) |=> res_valid);

   a_r7_wide_waits: assert property (@(posedge clk) disable iff (rst)
      (cmd_valid && cmd_op == OP_SRCH_A && cmd_wide) |=> !res_valid);

   a_r7_orphan_b: assert property (@(posedge clk) disable iff (rst)
      (cmd_valid && cmd_op == OP_SRCH_B &&
       !$past(cmd_valid && cmd_op == OP_SRCH_A && cmd_wide)) |=> !res_valid);

   a_r9_write_quiet: assert property (@(posedge clk) disable iff (rst)
      (cmd_valid && (cmd_op == OP_WRITE || cmd_op == OP_LEARN)) |=> !res_valid);

   a_r11_hold: assert property (@(posedge clk) disable iff (rst)
      !res_valid |-> $stable(match_vec));

   a_r8_lowest: assert property (@(posedge clk) disable iff (rst)
      hit |-> (match_vec[hit_idx] && (match_vec & below) == '0));

   a_r8_none: assert property (@(posedge clk) disable iff (rst)
      !hit |-> (match_vec == '0 && hit_idx == '0));
endmodule

bind skm_unit skm_unit_chk #(.NENT(NENT)) u_chk (
   .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
   .cmd_wide(cmd_wide), .res_valid(res_valid), .match_vec(match_vec),
   .hit(hit), .hit_idx(hit_idx)
);

// File: tb/skm_unit_test.sv
module skm_unit_test;
   localparam int DW = 72;
   localparam int NE = 16;

   logic clk = 0;
   logic rst = 1;
   logic cfg_we = 0, cfg_bank = 0;
   logic [4:0] cfg_addr = 0;
   logic [DW-1:0] cfg_data = 0;
   logic rd_bank = 0;
   logic [4:0] rd_addr = 0;
   logic [DW-1:0] rd_data;
   logic cmd_valid = 0;
   logic [1:0] cmd_op = 0;
   logic cmd_wide = 0, cmd_tsel = 0, cmd_half = 0;
   logic [3:0] cmd_cidx = 0, cmd_midx = 0, cmd_entry = 0;
   logic [DW-1:0] cmd_data = 0;
   logic [3:0] tbl_rd_entry = 0;
   logic [2*DW-1:0] tbl_rd_data, tbl_rd_mask;
   logic res_valid, hit;
   logic [NE-1:0] match_vec;
   logic [3:0] hit_idx;

   int n_chk = 0, n_fail = 0;
   string cur_req = "R1";

   always #4 clk = ~clk;

   skm_unit uut (.*);

   // behavioural reference model
   logic [DW-1:0] m_cmp [32];
   logic [DW-1:0] m_msk [32];
   logic [2*DW-1:0] m_td [NE];
   logic [2*DW-1:0] m_tm [NE];
   logic m_pend, m_rv;
   logic [NE-1:0] m_pvec, m_vec;

   function automatic logic [NE-1:0] mvec(input logic [DW-1:0] key, input int h, input int mi);
      logic [NE-1:0] v;
      for (int e = 0; e < NE; e++) begin
         v[e] = 1'b1;
         for (int b = 0; b < DW; b++) begin
            if (m_msk[2*mi+h][b] && m_tm[e][h*DW+b] && (m_td[e][h*DW+b] != key[b]))
               v[e] = 1'b0;
         end
      end
      return v;
   endfunction

   always @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < 32; i++) begin m_cmp[i] = '0; m_msk[i] = '0; end
         for (int e = 0; e < NE; e++) begin m_td[e] = '0; m_tm[e] = '0; end
         m_pend = 0; m_rv = 0; m_pvec = '0; m_vec = '0;
      end else begin
         logic np;
         logic [NE-1:0] v;
         int c, mi, en, h;
         np = 0; m_rv = 0;
         c = int'(cmd_cidx); mi = int'(cmd_midx); en = int'(cmd_entry); h = int'(cmd_half);
         if (cmd_valid) begin
            case (cmd_op)
               2'd0: begin
                  v = mvec(cmd_data, 0, mi);
                  m_cmp[2*c] = cmd_data;
                  if (cmd_wide) begin np = 1; m_pvec = v; end
                  else begin m_rv = 1; m_vec = v; end
               end
               2'd1: if (m_pend) begin
                  v = mvec(cmd_data, 1, mi);
                  m_cmp[2*c+1] = cmd_data;
                  m_rv = 1; m_vec = m_pvec & v;
               end
               2'd2: for (int b = 0; b < DW; b++) begin
                  if (m_msk[2*mi+h][b]) begin
                     if (cmd_tsel) m_tm[en][h*DW+b] = cmd_data[b];
                     else          m_td[en][h*DW+b] = cmd_data[b];
                  end
               end
               default: m_td[en] = {m_cmp[2*c+1], m_cmp[2*c]};
            endcase
         end
         m_pend = np;
         if (cfg_we) begin
            if (cfg_bank) m_msk[cfg_addr] = cfg_data;
            else          m_cmp[cfg_addr] = cfg_data;
         end
      end
   end

   task automatic check(input string req, input string what, input logic [2*DW-1:0] act, input logic [2*DW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic cmp_outputs();
      logic eh;
      logic [3:0] ei;
      eh = 0; ei = 0;
      for (int e = NE - 1; e >= 0; e--) if (m_vec[e]) begin eh = 1; ei = 4'(e); end
      check(cur_req, "res_valid", 144'(res_valid), 144'(m_rv));
      check(cur_req, "match_vec", 144'(match_vec), 144'(m_vec));
      check("R8", "hit", 144'(hit), 144'(eh));
      check("R8", "hit_idx", 144'(hit_idx), 144'(ei));
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
      cfg_we = 0; cmd_valid = 0;
      cmp_outputs();
   endtask

   task automatic cfg(input logic bank, input int addr, input logic [DW-1:0] d);
      cfg_we = 1; cfg_bank = bank; cfg_addr = 5'(addr); cfg_data = d;
      tick();
   endtask

   task automatic cmd(input int op, input logic wide, input int ci, input int mi,
                      input int en, input logic ts, input logic hf, input logic [DW-1:0] d);
      cmd_valid = 1; cmd_op = 2'(op); cmd_wide = wide; cmd_cidx = 4'(ci); cmd_midx = 4'(mi);
      cmd_entry = 4'(en); cmd_tsel = ts; cmd_half = hf; cmd_data = d;
      tick();
   endtask

   task automatic rb_reg(input string req, input logic bank, input int addr, input logic [DW-1:0] exp);
      rd_bank = bank; rd_addr = 5'(addr);
      #1;
      check(req, "rd_data", 144'(rd_data), 144'(exp));
   endtask

   task automatic rb_tbl(input string req, input int en, input logic [2*DW-1:0] ed, input logic [2*DW-1:0] em);
      tbl_rd_entry = 4'(en);
      #1;
      check(req, "tbl_rd_data", tbl_rd_data, ed);
      check(req, "tbl_rd_mask", tbl_rd_mask, em);
   endtask

   initial begin
      #(8 * 150000);
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 0;
      cur_req = "R1";
      cmp_outputs();
      check("R1", "match_vec zero", 144'(match_vec), 144'(0));
      rb_reg("R1", 1'b0, 31, '0);
      rb_reg("R1", 1'b1, 0, '0);
      rb_tbl("R1", 15, '0, '0);

      // all care bits zero after reset: every entry matches
      cur_req = "R5";
      cmd(0, 0, 0, 0, 0, 0, 0, 72'h123);
      check("R6", "match all", 144'(match_vec), 144'(16'hFFFF));
      check("R8", "idx0", 144'(hit_idx), 144'(0));

      // masks: pair 0 all ones, pair 1 even ignores low byte, pair 2 even only bits 7:4
      cur_req = "R2";
      cfg(1, 0, {DW{1'b1}});
      cfg(1, 1, {DW{1'b1}});
      cfg(1, 2, ~72'hFF);
      cfg(1, 3, {DW{1'b1}});
      cfg(1, 4, 72'hF0);
      cfg(1, 8, {DW{1'b1}});
      cfg(1, 9, ~72'hFF);
      rb_reg("R2", 1'b1, 2, ~72'hFF);
      rb_reg("R2", 1'b1, 4, 72'hF0);

      cur_req = "R9";
      for (int e = 0; e < NE; e++) begin
         cmd(2, 0, 0, 0, e, 0, 0, 72'h5A00 + 72'(e));
         cmd(2, 0, 0, 0, e, 0, 1, 72'hA500 + 72'(e));
         cmd(2, 0, 0, 0, e, 1, 0, {DW{1'b1}});
         cmd(2, 0, 0, 0, e, 1, 1, {DW{1'b1}});
      end
      rb_tbl("R9", 4, {72'hA504, 72'h5A04}, {2*DW{1'b1}});

      cur_req = "R6";
      cmd(0, 0, 1, 0, 0, 0, 0, 72'h5A03);
      check("R6", "single", 144'(match_vec), 144'(16'h0008));
      check("R8", "idx3", 144'(hit_idx), 144'(3));
      cur_req = "R4";
      cmd(0, 0, 1, 1, 0, 0, 0, 72'h5A77);
      check("R4", "low byte ignored", 144'(match_vec), 144'(16'hFFFF));
      cur_req = "R6";
      cmd(0, 0, 1, 0, 0, 0, 0, 72'h5B00);
      check("R8", "no hit", 144'(hit), 144'(0));

      cur_req = "R7";
      cmd(0, 1, 2, 0, 0, 0, 0, 72'h5A05);
      check("R7", "no result after A", 144'(res_valid), 144'(0));
      cmd(1, 0, 2, 0, 0, 0, 0, 72'hA505);
      check("R7", "wide match", 144'(match_vec), 144'(16'h0020));
      cmd(0, 1, 2, 0, 0, 0, 0, 72'h5A05);
      cmd(1, 0, 2, 0, 0, 0, 0, 72'hA506);
      check("R7", "hi miss", 144'(match_vec), 144'(0));
      cmd(1, 0, 3, 0, 0, 0, 0, 72'hA501);
      check("R7", "orphan B", 144'(res_valid), 144'(0));
      rb_reg("R7", 1'b0, 7, '0);
      cur_req = "R4";
      cmd(0, 1, 2, 4, 0, 0, 0, 72'h5A02);
      cmd(1, 0, 2, 4, 0, 0, 0, 72'hA5EE);
      check("R4", "odd mask pair 4", 144'(match_vec), 144'(16'h0004));

      cur_req = "R9";
      cmd(2, 0, 0, 2, 9, 0, 0, {DW{1'b1}});
      rb_tbl("R9", 9, {72'hA509, 72'h5AF9}, {2*DW{1'b1}});

      cur_req = "R3";
      cmd(0, 1, 7, 0, 0, 0, 0, 72'h123);
      cmd(1, 0, 7, 0, 0, 0, 0, 72'h456);
      rb_reg("R3", 1'b0, 14, 72'h123);
      rb_reg("R3", 1'b0, 15, 72'h456);
      cur_req = "R10";
      cmd(3, 0, 7, 0, 15, 0, 0, '0);
      rb_tbl("R10", 15, {72'h456, 72'h123}, {2*DW{1'b1}});
      cmd(0, 0, 0, 0, 0, 0, 0, 72'h123);
      check("R10", "learned entry", 144'(match_vec), 144'(16'h8000));
      check("R8", "idx15", 144'(hit_idx), 144'(15));

      cur_req = "R11";
      for (int i = 0; i < 3; i++) tick();
      check("R11", "hold", 144'(match_vec), 144'(16'h8000));

      // random phase, compared every cycle against the model
      cur_req = "R5";
      for (int i = 0; i < 3000; i++) begin
         int r, e, h;
         logic [DW-1:0] k;
         r = int'($urandom % 10);
         e = int'($urandom % NE);
         h = int'($urandom % 2);
         k = (h == 1) ? m_td[e][2*DW-1:DW] : m_td[e][DW-1:0];
         if ($urandom % 3 == 0) k = k ^ (72'(1) << ($urandom % DW));
         if (r == 0)
            cfg(1'($urandom % 2), int'($urandom % 32),
                {8'($urandom), 32'($urandom), 32'($urandom)} | (($urandom % 2 == 1) ? ~72'hFFF : 72'h0));
         else if (r < 4)
            cmd(0, 1'($urandom % 2), int'($urandom % 16), int'($urandom % 6), 0, 0, 0, m_td[e][DW-1:0] ^ (($urandom % 4 == 0) ? 72'h10 : 72'h0));
         else if (r < 7)
            cmd(1, 0, int'($urandom % 16), int'($urandom % 6), 0, 0, 0, k);
         else if (r < 9)
            cmd(2, 0, 0, int'($urandom % 6), e, 1'($urandom % 2), 1'(h), {8'($urandom), 32'($urandom), 32'($urandom)});
         else
            cmd(3, 0, int'($urandom % 16), 0, e, 0, 0, '0);
         if (i % 50 == 0) begin
            rb_tbl("R12", e, m_td[e], m_tm[e]);
            rb_reg("R2", 1'(h), e * 2, h == 1 ? m_msk[e*2] : m_cmp[e*2]);
         end
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule